// File: doc/BRIEF.md
# Power-of-Two PI Loop Filter and Phase Accumulator

This block closes the digital tracking loops of an OFDM receiver once the preamble is over. A pilot-based detector hands it one signed phase-error word for each OFDM symbol, along with an update strobe. The block passes that word through a proportional-plus-integral filter. Both gains are powers of two, so each path is only an arithmetic shift and no multiplier is needed. The filter output is the frequency correction word. It is also summed into a wrapping phase accumulator (NCO), whose value is the phase correction word for a de-rotator or an interpolator.

A single structure serves both loops. A mode input picks the coefficient set:

- Carrier recovery uses a proportional shift of 11 and an integral shift of 14.
- Sampling-timing recovery uses a proportional shift of 12 and an integral shift of 17.

A synchronous clear starts a new packet. The integrator must never hold a sum built from two different scalings. For that reason the coefficient set is sampled only on the first update after a reset or a clear, and it is then held until the next clear.

A two-state controller sequences this:

- **ST_IDLE** is entered at reset and on every clear. In this state the mode input is followed.
- **ST_TRACK** is entered from ST_IDLE on the first update, through the transition *first update*. In this state the sampled mode is frozen.
- The transition *clear* returns ST_TRACK (or ST_IDLE) to ST_IDLE.

Top module: `pi_shift_nco`

## Requirements
- R1: After reset, `phase_o` and `freq_o` are both zero.
- R2: A cycle with `clr_i` high sets the integrator, `phase_o` and `freq_o` to zero at the next clock edge. This holds even when `err_vld_i` is high in the same cycle.
- R3: On each update, the 16-bit error is first placed in the upper 16 bits of a 32-bit word (error times 2^16), giving E. The integrator then becomes I + (E >>> KI). `freq_o` becomes (E >>> KP) plus the new integrator value. The shifts are KP=11, KI=14 for `mode_i`=0 (carrier) and KP=12, KI=17 for `mode_i`=1 (timing).
- R4: Every shift rounds toward negative infinity. For example, an error of -1 in timing mode adds -1 to the integrator, while an error of +1 adds 0.
- R5: The integrator and the output sum saturate at 2^31-1 and -2^31 instead of wrapping.
- R6: On each update, `phase_o` becomes (previous `phase_o` + new `freq_o`) modulo 2^32.
- R7: In a cycle with neither an update nor a clear, `phase_o` and `freq_o` keep their values, whatever `err_i` holds.
- R8: The coefficient set is taken from `mode_i` on the first update after a reset or a clear. Mode changes made while idle therefore count.
- R9: A change of `mode_i` after that first update has no effect until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear at the start of a packet |
| mode_i | input | 1 | Coefficient set: 0 carrier, 1 timing |
| err_vld_i | input | 1 | One-cycle strobe marking a new error word |
| err_i | input | 16 | Signed phase-error word |
| phase_o | output | 32 | NCO phase correction word, wrapping |
| freq_o | output | 32 | Signed filter output, the frequency correction word |

## Verification
The hardest state to reach is integrator saturation. With a full-scale error, the integrator grows by only 2^17 per update in carrier mode. The bench therefore drives more than sixteen thousand consecutive full-scale updates in each direction, and checks every update against an arithmetic model that clamps. Coarse sweeps over the whole error range in both modes cover the shift and rounding arithmetic. Separate sequences change the mode while the block is idle and while it is tracking, and assert the clear in the same cycle as an update.

// File: rtl/pinco_pkg.sv
package pinco_pkg;

    typedef enum logic {
        MODE_CARRIER = 1'b0,
        MODE_TIMING  = 1'b1
    } loop_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_e;

endpackage

// File: rtl/pinco_ctrl.sv
module pinco_ctrl
    import pinco_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       vld,
    input  loop_mode_e mode_in,
    output trk_state_e st_q,
    output loop_mode_e act_mode_q,
    output loop_mode_e eff_mode,
    output logic       upd
);

    trk_state_e st_d;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (!clr && vld) st_d = ST_TRACK;
            ST_TRACK: if (clr)         st_d = ST_IDLE;
            default:                   st_d = ST_IDLE;
        endcase
        if (clr) st_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs: mode capture on the first update of a packet
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_mode_q <= MODE_CARRIER;
        end else if (!clr && vld && st_q == ST_IDLE) begin
            act_mode_q <= mode_in;
        end
    end

    assign eff_mode = (st_q == ST_IDLE) ? mode_in : act_mode_q;
    assign upd      = vld && !clr;

endmodule

// File: rtl/pinco_filter.sv
module pinco_filter
    import pinco_pkg::*;
#(
    parameter int ERR_W = 16,
    parameter int ACC_W = 32,
    parameter int CR_KP = 11,
    parameter int CR_KI = 14,
    parameter int TR_KP = 12,
    parameter int TR_KI = 17
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    upd,
    input  loop_mode_e              mode,
    input  logic signed [ERR_W-1:0] err,
    output logic signed [ACC_W-1:0] integ_q,
    output logic signed [ACC_W-1:0] freq_d,
    output logic signed [ACC_W-1:0] freq_q
);

    localparam int ALIGN = ACC_W - ERR_W;
    localparam logic signed [ACC_W-1:0] S_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] S_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    function automatic logic signed [ACC_W-1:0] sat_add(
        input logic signed [ACC_W-1:0] a,
        input logic signed [ACC_W-1:0] b
    );
        logic [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
        if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? S_MIN : S_MAX;
        return s[ACC_W-1:0];
    endfunction

    int kp_sh;
    int ki_sh;
    logic signed [ACC_W-1:0] e_ext;
    logic signed [ACC_W-1:0] prop;
    logic signed [ACC_W-1:0] inc;
    logic signed [ACC_W-1:0] integ_d;

    always_comb begin
        unique case (mode)
            MODE_CARRIER: begin kp_sh = CR_KP; ki_sh = CR_KI; end
            MODE_TIMING:  begin kp_sh = TR_KP; ki_sh = TR_KI; end
            default:      begin kp_sh = CR_KP; ki_sh = CR_KI; end
        endcase
    end

    generate
        if (ALIGN > 0) begin : g_align
            assign e_ext = {err, {ALIGN{1'b0}}};
        end else begin : g_noalign
            assign e_ext = err[ERR_W-1 -: ACC_W];
        end
    endgenerate

    always_comb begin
        prop    = e_ext >>> kp_sh;
        inc     = e_ext >>> ki_sh;
        integ_d = sat_add(integ_q, inc);
        freq_d  = sat_add(prop, integ_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            integ_q <= '0;
            freq_q  <= '0;
        end else if (clr) begin
            integ_q <= '0;
            freq_q  <= '0;
        end else if (upd) begin
            integ_q <= integ_d;
            freq_q  <= freq_d;
        end
    end

endmodule

// File: rtl/pinco_nco.sv
module pinco_nco #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic [W-1:0] step,
    output logic [W-1:0] phase_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    phase_q <= '0;
        else if (clr)  phase_q <= '0;
        else if (upd)  phase_q <= phase_q + step;
    end

endmodule

// File: rtl/pi_shift_nco.sv
module pi_shift_nco
    import pinco_pkg::*;
#(
    parameter int ERR_W = 16,
    parameter int ACC_W = 32,
    parameter int CR_KP = 11,
    parameter int CR_KI = 14,
    parameter int TR_KP = 12,
    parameter int TR_KI = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             mode_i,
    input  logic             err_vld_i,
    input  logic [ERR_W-1:0] err_i,
    output logic [ACC_W-1:0] phase_o,
    output logic [ACC_W-1:0] freq_o
);

    trk_state_e              st_q;
    loop_mode_e              act_mode;
    loop_mode_e              eff_mode;
    logic                    upd;
    logic signed [ACC_W-1:0] integ_q;
    logic signed [ACC_W-1:0] freq_d;
    logic signed [ACC_W-1:0] freq_q;

    pinco_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_i),
        .vld        (err_vld_i),
        .mode_in    (loop_mode_e'(mode_i)),
        .st_q       (st_q),
        .act_mode_q (act_mode),
        .eff_mode   (eff_mode),
        .upd        (upd)
    );

    pinco_filter #(
        .ERR_W (ERR_W),
        .ACC_W (ACC_W),
        .CR_KP (CR_KP),
        .CR_KI (CR_KI),
        .TR_KP (TR_KP),
        .TR_KI (TR_KI)
    ) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_i),
        .upd     (upd),
        .mode    (eff_mode),
        .err     (err_i),
        .integ_q (integ_q),
        .freq_d  (freq_d),
        .freq_q  (freq_q)
    );

    pinco_nco #(
        .W (ACC_W)
    ) u_nco (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_i),
        .upd     (upd),
        .step    (freq_d),
        .phase_q (phase_o)
    );

    assign freq_o = freq_q;

endmodule

// File: rtl/pinco_chk.sv
module pinco_chk
    import pinco_pkg::*;
#(
    parameter int ERR_W = 16,
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             err_vld_i,
    input logic [ERR_W-1:0] err_i,
    input logic [ACC_W-1:0] phase_o,
    input logic [ACC_W-1:0] freq_o,
    input logic [ACC_W-1:0] integ_q,
    input trk_state_e       st_q,
    input loop_mode_e       act_mode
);

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (phase_o == '0 && freq_o == '0 && integ_q == '0 && st_q == ST_IDLE));

    // R6
    nco_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld_i && !clr_i) |=> (phase_o == ACC_W'($past(phase_o) + freq_o)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_vld_i && !clr_i) |=> ($stable(phase_o) && $stable(freq_o)));

    // R5
    no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld_i && !clr_i && !err_i[ERR_W-1])
        |=> ($signed(integ_q) >= $signed($past(integ_q))));

    // R5
    no_wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld_i && !clr_i && err_i[ERR_W-1])
        |=> ($signed(integ_q) <= $signed($past(integ_q))));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TRACK && !clr_i) |=> $stable(act_mode));

endmodule

bind pi_shift_nco pinco_chk #(
    .ERR_W (ERR_W),
    .ACC_W (ACC_W)
) u_pinco_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .err_vld_i (err_vld_i),
    .err_i     (err_i),
    .phase_o   (phase_o),
    .freq_o    (freq_o),
    .integ_q   (integ_q),
    .st_q      (st_q),
    .act_mode  (act_mode)
);

// File: tb/test_pi_shift_nco.sv
`timescale 1ns/1ps
module test_pi_shift_nco;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic        mode_i = 1'b0;
    logic        err_vld_i = 1'b0;
    logic [15:0] err_i = '0;
    logic [31:0] phase_o;
    logic [31:0] freq_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    longint m_int, m_freq, m_ph;
    bit     m_idle;
    bit     m_mode;

    localparam longint SMAX = 64'sd2147483647;
    localparam longint SMIN = -64'sd2147483648;

    always #2 clk = ~clk;

    pi_shift_nco i_pi_shift_nco (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_i),
        .mode_i    (mode_i),
        .err_vld_i (err_vld_i),
        .err_i     (err_i),
        .phase_o   (phase_o),
        .freq_o    (freq_o)
    );

    function automatic longint clamp(input longint v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    task automatic check_out(input string req);
        longint f_act;
        f_act = longint'($signed(freq_o));
        checks++;
        if (f_act != m_freq || longint'(phase_o) != m_ph) begin
            errors++;
            $display("FAIL %s freq=%0d phase=%0d expected freq=%0d phase=%0d",
                     req, f_act, phase_o, m_freq, m_ph);
        end
    endtask

    task automatic model_upd(input int e);
        longint ex, p, inc;
        int kp, ki;
        if (m_idle) begin m_mode = mode_i; m_idle = 1'b0; end
        kp = m_mode ? 12 : 11;
        ki = m_mode ? 17 : 14;
        ex = longint'(e) * 65536;
        p = ex >>> kp;
        inc = ex >>> ki;
        m_int = clamp(m_int + inc);
        m_freq = clamp(p + m_int);
        m_ph = (m_ph + m_freq) & 64'h00000000FFFFFFFF;
    endtask

    task automatic do_upd(input int e, input string req);
        @(negedge clk);
        err_i = 16'(e);
        err_vld_i = 1'b1;
        model_upd(e);
        @(negedge clk);
        err_vld_i = 1'b0;
        check_out(req);
    endtask

    task automatic do_clr(input bit with_vld, input string req);
        @(negedge clk);
        clr_i = 1'b1;
        err_vld_i = with_vld;
        err_i = 16'h7fff;
        @(negedge clk);
        clr_i = 1'b0;
        err_vld_i = 1'b0;
        m_int = 0; m_freq = 0; m_ph = 0; m_idle = 1'b1;
        check_out(req);
    endtask

    initial begin
        m_int = 0; m_freq = 0; m_ph = 0; m_idle = 1'b1; m_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1");

        // R3 R6: coarse sweep over the full error range in both modes
        for (int md = 0; md < 2; md++) begin
            mode_i = md[0];
            do_clr(1'b0, "R2");
            for (int k = 0; k < 256; k++) do_upd(-32768 + k * 257, "R3_R6");
        end

        // R4: floor rounding on small values, timing mode
        mode_i = 1'b1;
        do_clr(1'b0, "R2");
        do_upd(-1, "R4");
        do_upd(-1, "R4");
        do_upd(1, "R4");
        do_upd(3, "R4");
        do_upd(-3, "R4");

        // R7: idle cycles with a changing error word
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            err_i = 16'(k * 4099);
            @(negedge clk);
            check_out("R7");
        end

        // R2: clear in the same cycle as an update
        do_upd(1234, "R3");
        do_clr(1'b1, "R2");

        // R8: mode changed while idle counts
        mode_i = 1'b0;
        do_clr(1'b0, "R2");
        mode_i = 1'b1;
        do_upd(20000, "R8");
        // R9: a later change has no effect
        mode_i = 1'b0;
        do_upd(20000, "R9");
        do_upd(-7777, "R9");
        mode_i = 1'b1;
        do_clr(1'b0, "R2");
        mode_i = 1'b0;
        do_upd(-5000, "R8");
        mode_i = 1'b1;
        do_upd(-5000, "R9");

        // R5: positive and negative saturation, carrier mode
        mode_i = 1'b0;
        do_clr(1'b0, "R2");
        for (int k = 0; k < 16500; k++) do_upd(32767, "R5");
        do_upd(-1, "R5");
        do_clr(1'b0, "R2");
        for (int k = 0; k < 16500; k++) do_upd(-32768, "R5");
        do_upd(0, "R5");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule